// File: doc/BRIEF.md
# Clock Output Enable and Shutdown Control

This block sets the drive state of each output in a bank of clock outputs. Each output is in one of three states. In the running state the source clock passes through. In the held state the output is driven low. In the high-impedance state the output driver is switched off. A single shared control pin sets the state, together with a polarity bit, a mode bit and two configuration bits for each output. The mode bit gives the pin one of two roles. It can stop the whole bank at once, or it can stop only the outputs that have chosen to obey it. Each output also chooses whether stopping means held low or released to high impedance.

Each output has its own source clock. The control pin passes through a two-stage synchronizer inside each output's clock domain. A state register updates only on the falling edge of that output's clock. As a result, the gated clock never shows a shortened high phase when it stops or restarts. The state of each output is also available as a 2-bit code, for use by a driver or pad stage.

Top module: `oe_shutdown_ctl`

## Requirements
- R1: While the synchronous reset is high, every output is in high impedance: state code 00, driver enable low, clock output low.
- R2: While the configuration-valid input is low, every output is in high impedance.
- R3: An output whose high-impedance select bit is 1 is in high impedance, whatever its enable bit, the mode bit and the pin.
- R4: In per-output mode (mode bit 0), an output whose enable bit is 0 runs, whatever the level of the pin.
- R5: In per-output mode, an output whose enable bit is 1 is held (state code 10) while the pin is asserted, and runs (state code 01) while the pin is deasserted.
- R6: The pin counts as asserted when its level equals the polarity bit. With polarity 0 (the reset default) the pin is active low; with polarity 1 it is active high.
- R7: In bank-shutdown mode (mode bit 1), asserting the pin holds every output that is not in high impedance, whatever its enable bit. Deasserting the pin lets those outputs run.
- R8: A running output copies its source clock, and a held or high-impedance output is low. The driver enable is 1 for the running and held states and 0 for high impedance. The state code for output n is at bits [2n+1:2n].
- R9: The state of an output changes only on the falling edge of its own clock, so every high phase that appears on the output lasts the full source high phase.
- R10: A pin change is captured on the next two rising edges of the output clock and takes effect on the falling edge after the second of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | N_OUT | Source clock of each output |
| rst_i | input | 1 | Synchronous active-high reset, sampled on each falling edge |
| cfg_valid_i | input | 1 | Configuration valid; 0 forces every output to high impedance |
| ctl_pin_i | input | 1 | Shared shutdown / enable control pin (asynchronous) |
| pin_pol_i | input | 1 | Pin level that counts as asserted |
| gshut_mode_i | input | 1 | 1: pin stops the whole bank; 0: pin stops only enabled outputs |
| hiz_sel_i | input | N_OUT | Per output: 1 selects high impedance |
| en_ctl_i | input | N_OUT | Per output: 1 makes the output obey the pin in per-output mode |
| out_clk_o | output | N_OUT | Gated clock of each output |
| out_oe_o | output | N_OUT | Driver enable of each output; 0 means high impedance |
| state_o | output | 2*N_OUT | State code of each output: 00 high-Z, 01 running, 10 held |

## Verification
The hardest case to reach from the ports is a stop or restart that happens in the middle of a clock high phase. If the gate were wrong, this is where a shortened pulse would appear. The stimulus changes the pin and the configuration many times in a row, so that output 0 switches between running and held again and again. A bench monitor times every high phase on that output and reports any that is shorter than the source half period. The exact capture delay of the synchronizer is measured separately. After one pin change, the bench samples the state code once just before and once just after the falling edge where the change should take effect.

// File: rtl/oe_ctl_pkg.sv
`timescale 1ns/1ps
package oe_ctl_pkg;
  typedef enum logic [1:0] {
    DRV_HIZ  = 2'b00,
    DRV_RUN  = 2'b01,
    DRV_HOLD = 2'b10
  } drv_state_e;
endpackage

// File: rtl/oe_pin_sync.sv
`timescale 1ns/1ps
module oe_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i) chain_q <= d_i;
    end else begin : g_multi
      always_ff @(posedge clk_i) chain_q <= {chain_q[LAST-1:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/oe_stop_decode.sv
`timescale 1ns/1ps
module oe_stop_decode
  import oe_ctl_pkg::*;
(
  input  logic       cfg_valid_i,
  input  logic       hiz_sel_i,
  input  logic       gshut_mode_i,
  input  logic       en_ctl_i,
  input  logic       pin_act_i,
  output drv_state_e next_o
);
  always_comb begin
    if (!cfg_valid_i || hiz_sel_i) begin
      next_o = DRV_HIZ;
    end else if (gshut_mode_i) begin
      next_o = pin_act_i ? DRV_HOLD : DRV_RUN;
    end else if (en_ctl_i && pin_act_i) begin
      next_o = DRV_HOLD;
    end else begin
      next_o = DRV_RUN;
    end
  end
endmodule

// File: rtl/oe_clk_slice.sv
`timescale 1ns/1ps
module oe_clk_slice
  import oe_ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  drv_state_e next_i,
  output logic       clk_o,
  output logic       oe_o,
  output logic [1:0] state_o
);
  drv_state_e state_q;
  logic       gate_q;
  logic       oe_q;

  // state moves only while the clock is low
  always_ff @(negedge clk_i) begin
    if (rst_i) begin
      state_q <= DRV_HIZ;
      gate_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= next_i;
      gate_q  <= (next_i == DRV_RUN);
      oe_q    <= (next_i != DRV_HIZ);
    end
  end

  assign clk_o   = clk_i & gate_q;
  assign oe_o    = oe_q;
  assign state_o = state_q;
endmodule

// File: rtl/oe_shutdown_ctl.sv
`timescale 1ns/1ps
module oe_shutdown_ctl
  import oe_ctl_pkg::*;
#(
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic [N_OUT-1:0]   clk_i,
  input  logic               rst_i,
  input  logic               cfg_valid_i,
  input  logic               ctl_pin_i,
  input  logic               pin_pol_i,
  input  logic               gshut_mode_i,
  input  logic [N_OUT-1:0]   hiz_sel_i,
  input  logic [N_OUT-1:0]   en_ctl_i,
  output logic [N_OUT-1:0]   out_clk_o,
  output logic [N_OUT-1:0]   out_oe_o,
  output logic [2*N_OUT-1:0] state_o
);
  localparam int CODE_W = 2;

  generate
    for (genvar g = 0; g < N_OUT; g++) begin : g_out
      logic       pin_s;
      logic       pin_act;
      drv_state_e next_st;
      logic [1:0] code;

      oe_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i[g]),
        .d_i   (ctl_pin_i),
        .q_o   (pin_s)
      );

      assign pin_act = (pin_s == pin_pol_i);

      oe_stop_decode u_dec (
        .cfg_valid_i  (cfg_valid_i),
        .hiz_sel_i    (hiz_sel_i[g]),
        .gshut_mode_i (gshut_mode_i),
        .en_ctl_i     (en_ctl_i[g]),
        .pin_act_i    (pin_act),
        .next_o       (next_st)
      );

      oe_clk_slice u_slice (
        .clk_i   (clk_i[g]),
        .rst_i   (rst_i),
        .next_i  (next_st),
        .clk_o   (out_clk_o[g]),
        .oe_o    (out_oe_o[g]),
        .state_o (code)
      );

      assign state_o[CODE_W*g +: CODE_W] = code;
    end
  endgenerate
endmodule

// File: rtl/oe_shutdown_ctl_chk.sv
`timescale 1ns/1ps
module oe_shutdown_ctl_chk #(
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic [N_OUT-1:0]   clk_i,
  input logic               rst_i,
  input logic               cfg_valid_i,
  input logic               ctl_pin_i,
  input logic               pin_pol_i,
  input logic               gshut_mode_i,
  input logic [N_OUT-1:0]   hiz_sel_i,
  input logic [N_OUT-1:0]   en_ctl_i,
  input logic [N_OUT-1:0]   out_clk_o,
  input logic [N_OUT-1:0]   out_oe_o,
  input logic [2*N_OUT-1:0] state_o
);
  localparam int LAG = SYNC_STAGES - 1;

  generate
    for (genvar g = 0; g < N_OUT; g++) begin : g_chk
      // R1
      reset_hiz_chk: assert property (@(posedge clk_i[g])
        rst_i |=> (state_o[2*g +: 2] == 2'b00) && !out_oe_o[g]);

      // R2 R3
      forced_hiz_chk: assert property (@(posedge clk_i[g]) disable iff (rst_i)
        (!cfg_valid_i || hiz_sel_i[g]) |=> (state_o[2*g +: 2] == 2'b00) && !out_oe_o[g]);

      // R4
      bypass_run_chk: assert property (@(posedge clk_i[g]) disable iff (rst_i)
        (cfg_valid_i && !hiz_sel_i[g] && !gshut_mode_i && !en_ctl_i[g])
        |=> (state_o[2*g +: 2] == 2'b01));

      // R5 R6 R7 R10
      pin_hold_chk: assert property (@(posedge clk_i[g]) disable iff (rst_i)
        (cfg_valid_i && !hiz_sel_i[g] && (gshut_mode_i || en_ctl_i[g])
         && ($past(ctl_pin_i, LAG) == pin_pol_i))
        |=> (state_o[2*g +: 2] == 2'b10) && out_oe_o[g]);

      // R5 R6 R7 R10
      pin_release_chk: assert property (@(posedge clk_i[g]) disable iff (rst_i)
        (cfg_valid_i && !hiz_sel_i[g] && (gshut_mode_i || en_ctl_i[g])
         && ($past(ctl_pin_i, LAG) != pin_pol_i))
        |=> (state_o[2*g +: 2] == 2'b01));

      // R9
      always @(posedge out_clk_o[g]) begin
        rise_aligned_chk: assert (clk_i[g] == 1'b1)
          else $error("output %0d rose without its source clock", g);
      end

      // R9
      always @(negedge out_clk_o[g]) begin
        fall_aligned_chk: assert (clk_i[g] == 1'b0)
          else $error("output %0d fell during a source high phase", g);
      end
    end
  endgenerate
endmodule

bind oe_shutdown_ctl oe_shutdown_ctl_chk #(
  .N_OUT       (N_OUT),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (.*);

// File: tb/oe_shutdown_ctl_test.sv
`timescale 1ns/1ps
module oe_shutdown_ctl_test;
  localparam int N  = 4;
  localparam int SS = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst = 1'b1;
  logic         cfg_valid = 1'b0;
  logic         pin = 1'b1;
  logic         pol = 1'b0;
  logic         gmode = 1'b0;
  logic [N-1:0] hiz = '0;
  logic [N-1:0] en = '0;
  wire  [N-1:0]   out_clk;
  wire  [N-1:0]   out_oe;
  wire  [2*N-1:0] st;

  oe_shutdown_ctl #(.N_OUT(N), .SYNC_STAGES(SS)) uut (
    .clk_i        ({N{clk}}),
    .rst_i        (rst),
    .cfg_valid_i  (cfg_valid),
    .ctl_pin_i    (pin),
    .pin_pol_i    (pol),
    .gshut_mode_i (gmode),
    .hiz_sel_i    (hiz),
    .en_ctl_i     (en),
    .out_clk_o    (out_clk),
    .out_oe_o     (out_oe),
    .state_o      (st)
  );

  int checks = 0;
  int fails = 0;
  logic [2*N-1:0] q_st[$];
  string          q_tag[$];

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*N-1:0] model_state();
    logic [2*N-1:0] r;
    logic asserted;
    asserted = (pin == pol);
    for (int n = 0; n < N; n++) begin
      if (!cfg_valid || hiz[n])    r[2*n +: 2] = 2'b00;
      else if (gmode)              r[2*n +: 2] = asserted ? 2'b10 : 2'b01;
      else if (en[n] && asserted)  r[2*n +: 2] = 2'b10;
      else                         r[2*n +: 2] = 2'b01;
    end
    return r;
  endfunction

  // driver: apply a setting while the clock is low, push the expectation once settled
  task automatic drive(input logic cv, input logic pl, input logic gm,
                       input logic [N-1:0] hz, input logic [N-1:0] e,
                       input logic p, input string tag);
    @(negedge clk); #1;
    cfg_valid = cv; pol = pl; gmode = gm; hiz = hz; en = e; pin = p;
    repeat (4) @(posedge clk);
    q_st.push_back(model_state());
    q_tag.push_back(tag);
    @(posedge clk);
  endtask

  // monitor: pops one expectation and checks the high and the low phase
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q_st.size() > 0) begin
        logic [2*N-1:0] e;
        logic [N-1:0]   e_oe;
        logic [N-1:0]   e_run;
        string          tag;
        e = q_st.pop_front();
        tag = q_tag.pop_front();
        for (int n = 0; n < N; n++) begin
          e_oe[n]  = (e[2*n +: 2] != 2'b00);
          e_run[n] = (e[2*n +: 2] == 2'b01);
        end
        check({tag, " state"}, 16'(st), 16'(e));
        check({tag, " R8 driver enable"}, 16'(out_oe), 16'(e_oe));
        check({tag, " R8 clock high phase"}, 16'(out_clk), 16'(e_run));
        @(negedge clk); #1;
        check({tag, " R8 clock low phase"}, 16'(out_clk), 16'(0));
      end
    end
  end

  // R9: every high phase on output 0 must last the full source half period
  realtime t_rise = 0.0;
  int pulses = 0;
  int short_pulses = 0;
  always @(posedge out_clk[0]) t_rise = $realtime;
  always @(negedge out_clk[0]) begin
    pulses++;
    if ($realtime - t_rise < 2.4) short_pulses++;
  end

  bit done = 1'b0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1
    repeat (4) @(posedge clk); #1;
    check("R1 reset state", 16'(st), 16'(0));
    check("R1 reset driver enable", 16'(out_oe), 16'(0));
    check("R1 reset clock", 16'(out_clk), 16'(0));
    @(negedge clk); #1;
    rst = 1'b0;

    drive(1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, "R2 config not valid");
    drive(1'b1, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, "R4 enables clear pin asserted");
    drive(1'b1, 1'b0, 1'b0, 4'b0000, 4'b0101, 1'b0, "R5 enabled outputs held");
    drive(1'b1, 1'b0, 1'b0, 4'b0000, 4'b0101, 1'b1, "R5 pin released");
    drive(1'b1, 1'b1, 1'b0, 4'b0000, 4'b0101, 1'b1, "R6 active high asserted");
    drive(1'b1, 1'b1, 1'b0, 4'b0000, 4'b0101, 1'b0, "R6 active high released");
    drive(1'b1, 1'b0, 1'b0, 4'b1000, 4'b1111, 1'b0, "R3 high-Z beats enable");
    drive(1'b1, 1'b0, 1'b1, 4'b1000, 4'b1111, 1'b1, "R3 high-Z bank mode released");
    drive(1'b1, 1'b0, 1'b1, 4'b0010, 4'b0000, 1'b0, "R7 bank shutdown asserted");
    drive(1'b1, 1'b0, 1'b1, 4'b0010, 4'b0000, 1'b1, "R7 bank shutdown released");
    drive(1'b1, 1'b1, 1'b1, 4'b0000, 4'b1001, 1'b1, "R7 bank shutdown active high");
    for (int k = 0; k < 6; k++)
      drive(1'b1, 1'b0, 1'b0, 4'b0000, 4'b0001, k[0], "R9 repeated stop and start");
    drive(1'b1, 1'b0, 1'b0, 4'b0000, 4'b0001, 1'b1, "R10 setup");
    repeat (3) @(posedge clk);

    // R10: pin asserted while clock low; takes effect on the falling edge after two rising edges
    @(negedge clk); #1;
    pin = 1'b0;
    @(posedge clk);
    @(posedge clk); #1;
    check("R10 before capture edge", 16'(st[1:0]), 16'(2'b01));
    @(negedge clk); #1;
    check("R10 after capture edge", 16'(st[1:0]), 16'(2'b10));
    repeat (3) @(posedge clk);

    // R9
    check("R9 short pulses on output 0", 16'(short_pulses), 16'(0));
    check("R9 output 0 produced pulses", 16'(pulses > 4), 16'(1));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule